// File: doc/BRIEF.md
# Protected Interrupt Vector Base Selector

This block holds the control byte that decides where the interrupt vector table begins. The vector table sits either at address zero of program memory or at the first word of a boot region at the top of that memory. The size of the boot region, and so its first address, comes from a small configuration code on an input pin. The configuration code is not stored in the register. The selected base address is presented as a registered output for the fetch logic.

The selection cannot be changed by a single write. A write that sets the unlock bit opens a short window. Only a write inside that window, with the unlock bit written as zero, moves the select bit. While the window is open, and until the instruction after the select write retires, the block asserts an interrupt-block output. This output holds off interrupt acceptance and leaves the core's global enable flag alone. Two lock inputs also block interrupts whenever execution runs in the region that does not hold the active vector table.

Top module: `vec_base_sel`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00, `vec_base` is 0 and `irq_block` is 0.
- R2: While the select bit is 0, `vec_base` is 0. While it is 1, `vec_base` equals 2^ADDR_W minus (2^BOOT_MIN_LG shifted left by `boot_size`). With the defaults these starts are 0x3F00, 0x3E00, 0x3C00 and 0x3800 for codes 0 to 3. `vec_base` follows `select` and `boot_size` one cycle after the edge that changes them.
- R3: Register layout as seen on `rd_data`. Bit 0 is the unlock flag and bit 1 is the select bit. Bits 3:2 always read 0. Bits 7:4 return the value from the last write.
- R4: A write with bit 0 = 0 while no window is open leaves the select bit unchanged.
- R5: A write with bit 0 = 1 opens a window. If nothing else is written, the unlock flag reads 1 for exactly 4 cycles after that write. A further arming write inside the window restarts the 4-cycle count.
- R6: A write with bit 0 = 0 inside an open window loads bit 1 into the select bit. The same write closes the window, so the unlock flag reads 0 on the next cycle.
- R7: `irq_block` is 1 from the cycle after an arming write. If no select write follows, it returns to 0 after 4 cycles.
- R8: After a select write, `irq_block` stays 1 until the cycle after the first `instr_done` pulse that comes strictly after the write. A pulse in the same cycle as the write does not count.
- R9: With select = 1, `lock_outside` = 1 and `in_boot` = 0, `irq_block` is 1 one cycle later. With `in_boot` = 1, this condition does not block.
- R10: With select = 0, `lock_inside` = 1 and `in_boot` = 1, `irq_block` is 1 one cycle later. With `in_boot` = 0, this condition does not block.
- R11: An arming write (bit 0 = 1) never changes the select bit, whatever its bit 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte written to the register |
| rd_data | output | 8 | Current register contents |
| instr_done | input | 1 | Pulse when an instruction completes |
| in_boot | input | 1 | High while execution runs in the boot region |
| boot_size | input | CFG_W | Boot region size code |
| lock_outside | input | 1 | Lock: block interrupts outside the boot region when vectors are in it |
| lock_inside | input | 1 | Lock: block interrupts inside the boot region when vectors are at zero |
| vec_base | output | ADDR_W | Registered vector table base address |
| irq_block | output | 1 | Registered interrupt-acceptance block |

## Verification
The properties assume that `instr_done` is a single-cycle pulse and that each write strobe lasts one cycle. They also assume that lock, region and size inputs are settled one cycle before their effect is checked. The bench drives every input one time unit after a rising edge and holds writes for exactly one edge. It changes lock and region inputs only while no unlock window or pending release is active, so each cause of `irq_block` is observed alone. An `instr_done` pulse is deliberately made to coincide with a select write, which exercises the rule that this pulse is ignored.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int REG_W   = 8;
  localparam int UNL_BIT = 0;
  localparam int SEL_BIT = 1;
  localparam int HI_LSB  = 4;
  localparam int HI_W    = REG_W - HI_LSB;
endpackage

// File: rtl/vbs_unlock.sv
module vbs_unlock
  import vbs_pkg::*;
#(
  parameter int WIN_CYC = 4,
  localparam int CNT_W = $clog2(WIN_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_unl,
  input  logic            wr_sel,
  input  logic [HI_W-1:0] wr_hi,
  input  logic            instr_done,
  output logic            sel_q,
  output logic            sel_nx,
  output logic            unl_open,
  output logic            pend_q,
  output logic            auto_nx,
  output logic [HI_W-1:0] hi_q
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             pend_nx;
  logic [HI_W-1:0]  hi_nx;

  assign unl_open = (cnt_q != '0);

  always_comb begin
    cnt_nx  = cnt_q;
    sel_nx  = sel_q;
    pend_nx = pend_q;
    hi_nx   = hi_q;
    if (pend_q && instr_done) pend_nx = 1'b0;
    if (unl_open) cnt_nx = cnt_q - CNT_W'(1);
    if (wr_en) begin
      hi_nx = wr_hi;
      if (wr_unl) begin
        cnt_nx = CNT_W'(WIN_CYC);
      end else if (unl_open) begin
        sel_nx  = wr_sel;
        cnt_nx  = '0;
        pend_nx = 1'b1;
      end
    end
  end

  assign auto_nx = (cnt_nx != '0) || pend_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      sel_q  <= sel_nx;
      pend_q <= pend_nx;
      hi_q   <= hi_nx;
    end
  end

  // R4: plain write with window closed keeps select
  assert_sel_guard_R4: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && !wr_unl && unl_open)) |=> $stable(sel_q));
  // R11: arming write keeps select
  assert_arm_keeps_sel_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_unl) |=> (sel_q == $past(sel_q)) && unl_open);
  // R6: select write closes the window
  assert_sel_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_unl && unl_open) |=> !unl_open && (sel_q == $past(wr_sel)));
  // R5: last window cycle without writes expires
  assert_window_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && cnt_q == CNT_W'(1)) |=> !unl_open);
endmodule

// File: rtl/vbs_base_calc.sv
module vbs_base_calc #(
  parameter int ADDR_W      = 14,
  parameter int CFG_W       = 2,
  parameter int BOOT_MIN_LG = 8,
  localparam int NUM_CFG = 1 << CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_nx,
  input  logic [CFG_W-1:0]  boot_size,
  output logic [ADDR_W-1:0] vec_base_q
);
  logic [ADDR_W-1:0] start_tbl [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_start
    localparam longint unsigned REGION = 64'd1 << (BOOT_MIN_LG + i);
    localparam longint unsigned START  = (64'd1 << ADDR_W) - REGION;
    assign start_tbl[i] = START[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) vec_base_q <= '0;
    else     vec_base_q <= sel_nx ? start_tbl[boot_size] : '0;
  end

  // R2: a boot-region base always lies above address zero
  assert_boot_base_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    sel_nx |=> (vec_base_q != '0));
endmodule

// File: rtl/vbs_irq_gate.sv
module vbs_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_nx,
  input  logic sel_nx,
  input  logic in_boot,
  input  logic lock_outside,
  input  logic lock_inside,
  output logic irq_block_q
);
  logic lock_hit;

  always_comb begin
    lock_hit = 1'b0;
    if (sel_nx && lock_outside && !in_boot) lock_hit = 1'b1;
    if (!sel_nx && lock_inside && in_boot)  lock_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_block_q <= 1'b0;
    else     irq_block_q <= auto_nx || lock_hit;
  end

  // R7: the automatic mask reaches the output one cycle later
  assert_auto_mask_R7: assert property (@(posedge clk) disable iff (rst)
    auto_nx |=> irq_block_q);
endmodule

// File: rtl/vec_base_sel.sv
module vec_base_sel
  import vbs_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int CFG_W       = 2,
  parameter int BOOT_MIN_LG = 8,
  parameter int WIN_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              instr_done,
  input  logic              in_boot,
  input  logic [CFG_W-1:0]  boot_size,
  input  logic              lock_outside,
  input  logic              lock_inside,
  output logic [ADDR_W-1:0] vec_base,
  output logic              irq_block
);
  logic            sel_q, sel_nx, unl_open, pend_q, auto_nx;
  logic [HI_W-1:0] hi_q;
  logic            unused_mid_bits;

  assign unused_mid_bits = ^wr_data[HI_LSB-1:SEL_BIT+1];

  vbs_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_unl(wr_data[UNL_BIT]), .wr_sel(wr_data[SEL_BIT]),
    .wr_hi(wr_data[REG_W-1:HI_LSB]), .instr_done(instr_done),
    .sel_q(sel_q), .sel_nx(sel_nx), .unl_open(unl_open),
    .pend_q(pend_q), .auto_nx(auto_nx), .hi_q(hi_q)
  );

  vbs_base_calc #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .BOOT_MIN_LG(BOOT_MIN_LG)) u_base (
    .clk(clk), .rst(rst), .sel_nx(sel_nx), .boot_size(boot_size),
    .vec_base_q(vec_base)
  );

  vbs_irq_gate u_gate (
    .clk(clk), .rst(rst), .auto_nx(auto_nx), .sel_nx(sel_nx),
    .in_boot(in_boot), .lock_outside(lock_outside), .lock_inside(lock_inside),
    .irq_block_q(irq_block)
  );

  assign rd_data = {hi_q, 2'b00, sel_q, unl_open};

  // R2: application placement means base zero
  assert_app_base_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> (vec_base == '0));
  // R8: a pending release keeps interrupts blocked
  assert_pend_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> irq_block);
  // R9: vectors in boot region, running outside, lock set
  assert_lock_outside_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_q && lock_outside && !in_boot) |=> irq_block);
  // R10: vectors at zero, running inside boot region, lock set
  assert_lock_inside_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && lock_inside && in_boot) |=> irq_block);
  // R3: middle bits never read as one
  assert_mid_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_data[3:2] == 2'b00);
endmodule

// File: tb/sim_vec_base_sel.sv
module sim_vec_base_sel;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 14;
  localparam int CFG_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic instr_done = 1'b0;
  logic in_boot = 1'b0;
  logic [CFG_W-1:0] boot_size = '0;
  logic lock_outside = 1'b0;
  logic lock_inside = 1'b0;
  logic [ADDR_W-1:0] vec_base;
  logic irq_block;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_base_sel u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .instr_done(instr_done), .in_boot(in_boot), .boot_size(boot_size),
    .lock_outside(lock_outside), .lock_inside(lock_inside),
    .vec_base(vec_base), .irq_block(irq_block)
  );

  function automatic int exp_start(int code);
    return (1 << ADDR_W) - (256 << code);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic retire();
    instr_done = 1'b1;
    step();
    instr_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 vec_base", vec_base, 0);
    chk("R1 irq_block", irq_block, 0);
  endtask

  task automatic t_layout();
    wr(8'hFC);
    chk("R3 layout readback", rd_data, 8'hF0);
    chk("R4 closed-window write keeps base", vec_base, 0);
    chk("R4 no block from plain write", irq_block, 0);
  endtask

  task automatic t_window_expire();
    wr(8'h01);
    chk("R5 unlock readback", rd_data, 8'h01);
    chk("R7 block after arm", irq_block, 1);
    for (int i = 0; i < 3; i++) step();
    chk("R5 flag on 4th cycle", rd_data[0], 1);
    chk("R7 block on 4th cycle", irq_block, 1);
    step();
    chk("R5 flag expired", rd_data[0], 0);
    chk("R7 block released", irq_block, 0);
  endtask

  task automatic t_arm_no_sel();
    wr(8'h03);
    chk("R11 arm keeps select", rd_data[1], 0);
    chk("R11 arm opens window", rd_data[0], 1);
    for (int i = 0; i < 4; i++) step();
    chk("R11 base unchanged", vec_base, 0);
  endtask

  task automatic t_rearm();
    wr(8'h01);
    for (int i = 0; i < 3; i++) step();
    wr(8'h01);
    for (int i = 0; i < 3; i++) step();
    chk("R5 rearm still open", rd_data[0], 1);
    step();
    chk("R5 rearm expired", rd_data[0], 0);
  endtask

  task automatic t_select();
    wr(8'h01);
    step();
    step();
    instr_done = 1'b1;
    wr(8'h52);
    instr_done = 1'b0;
    chk("R6 select loaded", rd_data, 8'h52);
    chk("R6 window closed", rd_data[0], 0);
    chk("R2 boot base code0", vec_base, exp_start(0));
    chk("R8 block after select", irq_block, 1);
    step();
    step();
    chk("R8 block held without retire", irq_block, 1);
    retire();
    chk("R8 block released after retire", irq_block, 0);
  endtask

  task automatic t_late_write();
    wr(8'h01);
    for (int i = 0; i < 4; i++) step();
    wr(8'h00);
    chk("R4 late write keeps select", rd_data, 8'h02);
    chk("R4 late write keeps base", vec_base, exp_start(0));
    chk("R4 no block from late write", irq_block, 0);
  endtask

  task automatic t_sizes();
    for (int c = 0; c < 4; c++) begin
      boot_size = CFG_W'(c);
      step();
      chk("R2 boot base per code", vec_base, exp_start(c));
    end
    boot_size = '0;
    step();
  endtask

  task automatic t_lock_outside();
    lock_outside = 1'b1;
    in_boot = 1'b0;
    step();
    chk("R9 blocked outside boot", irq_block, 1);
    in_boot = 1'b1;
    step();
    chk("R9 free inside boot", irq_block, 0);
    lock_outside = 1'b0;
    in_boot = 1'b0;
    step();
  endtask

  task automatic t_back_to_app();
    wr(8'h01);
    wr(8'h00);
    retire();
    chk("R6 select cleared", rd_data[1], 0);
    chk("R2 base back to zero", vec_base, 0);
  endtask

  task automatic t_lock_inside();
    lock_inside = 1'b1;
    in_boot = 1'b1;
    step();
    chk("R10 blocked inside boot", irq_block, 1);
    in_boot = 1'b0;
    step();
    chk("R10 free outside boot", irq_block, 0);
    lock_inside = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_layout();
    t_window_expire();
    t_arm_no_sel();
    t_rearm();
    t_select();
    t_late_write();
    t_sizes();
    t_lock_outside();
    t_back_to_app();
    t_lock_inside();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule